// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial transceiver. Its character format and bit rate are set at run time through a small byte-wide register port. Software chooses 5 to 8 data bits, one or two stop bits, and no parity, even parity or odd parity. It also loads a 16-bit rate divisor as two separate bytes. Every bit on the line lasts 16 ticks of a shared oversampling strobe, and that strobe fires once every `divisor` clocks. The bit rate is therefore fclk/(16*divisor), and a divisor of zero stands for 65536. A complete character on the line takes 7 to 12 bit times.

Each direction has a one-word holding register in front of its shift register. Software can queue the next transmit word while the current one is still shifting out. A received word stays readable while the next one arrives. Two status conditions drive interrupt lines, and each line has its own enable bit: a received word is waiting, and the transmit holding register is empty. The receiver detects a falling edge on the line and confirms the start bit at mid-bit, which rejects short glitches. It samples every following bit at oversample tick 8 of 16 and flags parity and stop-bit errors.

Register map (3-bit address, 8-bit data):

| Address | Write | Read |
|---|---|---|
| 0 | transmit holding register | receive data; the read clears the ready flag and both error flags |
| 1 | format | format |
| 2 | divisor low byte | divisor low byte |
| 3 | divisor high byte | divisor high byte |
| 4 | interrupt enables | interrupt enables |
| 5 | (ignored) | status |

Format register at address 1:
- bits [1:0]: data length minus 5
- bit 2: selects two stop bits
- bits [4:3]: parity mode (00 none, 01 even, 10 odd, 11 none)

Interrupt enable register at address 4:
- bit 0: enables the receive interrupt
- bit 1: enables the transmit interrupt

Status register at address 5:
- bit 0: a received word is ready
- bit 1: the transmit holding register is empty
- bit 2: parity error
- bit 3: framing error
- bit 4: the transmitter is fully idle

Top module: `uart_fmt_top`

## Requirements
- R1: The data length is 5 + format[1:0] bits, sent and received least significant bit first. Transmit ignores the unused upper bits of the written byte, and received data is read back zero-extended.
- R2: Format bit 2 selects two stop bits (high) or one stop bit (low). A transmitted character is 7 to 12 bit times long: start, data, optional parity, then stop bits.
- R3: Format[4:3] selects the parity mode: 01 even, 10 odd, 00 or 11 none. With even parity the data bits plus the parity bit carry an even number of ones. With odd parity they carry an odd number of ones.
- R4: The divisor is {address 3, address 2}, and each bit lasts 16*divisor clocks. A divisor of 0 gives 16*65536 clocks per bit.
- R5: The transmit path is double-buffered. A word written while a character is shifting waits in the holding register (status bit 1 = 0) and is sent immediately after the current character, with no idle gap.
- R6: The receive path is double-buffered. A completed character sets status bit 0 and stays readable at address 0 while the next character shifts in. Reading address 0 clears status bit 0.
- R7: irq_rx_o is high exactly when status bit 0 and enable bit 0 are both set. irq_tx_o is high exactly when status bit 1 and enable bit 1 are both set.
- R8: The receiver starts on a falling edge and re-checks the line at mid start bit. A low pulse shorter than half a bit produces no character.
- R9: A parity mismatch sets status bit 2. A stop bit sampled low sets status bit 3. Reading address 0 clears both bits.
- R10: After reset tx_o is high, both interrupts are low, the status reads 0x12, the format reads 0x03 and the divisor is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_re_i | input | 1 | register read strobe (has a side effect at address 0) |
| reg_addr_i | input | ADDR_W | register address |
| reg_wdata_i | input | 8 | write data |
| reg_rdata_o | output | 8 | read data, combinational from the address |
| rxd_i | input | 1 | serial receive line |
| tx_o | output | 1 | serial transmit line, high when idle |
| irq_rx_o | output | 1 | receive-ready interrupt |
| irq_tx_o | output | 1 | transmit-empty interrupt |

## Verification
The bound checker watches the following on every cycle:
- Strobe spacing for divisors above one.
- A high stop level during the last bit of every transmitted character.
- A loaded character length of 7 to 12 bits.
- A receive-ready flag that rises only from a completed character.
- The ready and error flags clearing after a data read.
- Each interrupt implying its status condition.

The bench scenarios cover what those properties cannot express. These are the exact serial bit patterns for each length, stop and parity mode, back-to-back transmission through the holding register, and mid-bit sampling with glitch rejection. They also include error injection, and the real bit duration for a divisor with a non-zero high byte and for a divisor of zero.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

  localparam int unsigned DATA_MAX  = 8;
  localparam int unsigned FRAME_MAX = 12;
  localparam int unsigned LEN_W     = 4;

  localparam int unsigned A_DATA = 0;
  localparam int unsigned A_FMT  = 1;
  localparam int unsigned A_DIVL = 2;
  localparam int unsigned A_DIVH = 3;
  localparam int unsigned A_MASK = 4;
  localparam int unsigned A_STAT = 5;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE3 = 2'b11
  } par_e;

  // Bit layout matches format register [4:0].
  typedef struct packed {
    par_e       par;
    logic       two_stop;
    logic [1:0] len_code;
  } fmt_t;

  function automatic logic [LEN_W-1:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic par_on(input par_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic par_calc(input par_e p, input logic [LEN_W-1:0] len,
                                    input logic [DATA_MAX-1:0] d);
    logic [DATA_MAX:0] m;
    m = (9'd1 << len) - 9'd1;
    return (^(d & m[DATA_MAX-1:0])) ^ (p == PAR_ODD);
  endfunction

endpackage

// File: rtl/uart_fmt_baud.sv
module uart_fmt_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // div_i - 1 wraps to all ones for a zero divisor: period 2**DIV_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || cnt_q == '0)  cnt_q <= div_i - DIV_W'(1);
    else                                cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uart_fmt_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  fmt_t                fmt_i,
  input  logic                hold_valid_i,
  input  logic [DATA_MAX-1:0] hold_data_i,
  output logic                take_o,
  output logic                busy_o,
  output logic [LEN_W-1:0]    bits_left_o,
  output logic                tx_o
);
  localparam int unsigned     SUB_W    = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [FRAME_MAX-1:0] shift_q, frame;
  logic [LEN_W-1:0]     left_q, nbits, len;
  logic [SUB_W-1:0]     sub_q;
  logic                 busy_q, finish, pen;

  always_comb begin
    len   = data_len(fmt_i.len_code);
    pen   = par_on(fmt_i.par);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (LEN_W'(i) < len) frame[1+i] = hold_data_i[i];
    end
    if (pen) frame[LEN_W'(1) + len] = par_calc(fmt_i.par, len, hold_data_i);
    nbits = LEN_W'(2) + len + {3'b000, pen} + {3'b000, fmt_i.two_stop};
  end

  assign finish = busy_q && tick_i && (sub_q == SUB_LAST) && (left_q == LEN_W'(1));
  assign take_o = hold_valid_i && (!busy_q || finish);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      busy_q  <= 1'b0;
    end else if (take_o) begin
      shift_q <= frame;
      left_q  <= nbits;
      sub_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (sub_q == SUB_LAST) begin
        sub_q   <= '0;
        shift_q <= {1'b1, shift_q[FRAME_MAX-1:1]};
        left_q  <= left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign tx_o        = busy_q ? shift_q[0] : 1'b1;
  assign busy_o      = busy_q;
  assign bits_left_o = left_q;
endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
  import uart_fmt_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [1:0]          len_code_i,
  input  par_e                par_i,
  input  logic                rxd_i,
  output logic                done_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int unsigned      SUB_W  = $clog2(OVS);
  localparam logic [SUB_W-1:0] SAMPLE = SUB_W'(OVS / 2 - 1);

  logic [2:0]          sync_q;
  logic                line, fall, busy_q, pbit_q, done_q, perr_q, ferr_q, pen;
  logic [SUB_W-1:0]    sub_q;
  logic [LEN_W-1:0]    idx_q, len;
  logic [DATA_MAX-1:0] data_q;

  assign line = sync_q[1];
  assign fall = sync_q[2] && !sync_q[1];
  assign len  = data_len(len_code_i);
  assign pen  = par_on(par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[1:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (fall) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
          data_q <= '0;
        end
      end else if (tick_i) begin
        sub_q <= sub_q + SUB_W'(1);
        if (sub_q == SAMPLE) begin
          if (idx_q == '0) begin
            // start bit confirmation
            if (line) busy_q <= 1'b0;
            else      idx_q  <= LEN_W'(1);
          end else if (idx_q <= len) begin
            data_q[3'(idx_q - LEN_W'(1))] <= line;
            idx_q <= idx_q + LEN_W'(1);
          end else if (pen && idx_q == len + LEN_W'(1)) begin
            pbit_q <= line;
            idx_q  <= idx_q + LEN_W'(1);
          end else begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            ferr_q <= !line;
            perr_q <= pen && (pbit_q != par_calc(par_i, len, data_q));
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
endmodule

// File: rtl/uart_fmt_top.sv
module uart_fmt_top
  import uart_fmt_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              rxd_i,
  output logic              tx_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  localparam int unsigned DIV_W = 2 * 8;

  logic [4:0]          fmt_q;
  logic [DIV_W-1:0]    div_q;
  logic [1:0]          mask_q;
  logic                hold_valid_q;
  logic [7:0]          hold_data_q;
  logic [DATA_MAX-1:0] rx_data_q, rx_byte;
  logic                rx_ready_q, perr_q, ferr_q;
  logic                tick, div_wr, rd_data;
  logic                wr_data, wr_fmt, wr_divl, wr_divh, wr_mask;
  logic                tx_take, tx_busy, rx_done, rx_perr, rx_ferr;
  logic [LEN_W-1:0]    tx_left;
  logic [7:0]          status;
  fmt_t                fmt;

  assign wr_data = reg_we_i && (reg_addr_i == ADDR_W'(A_DATA));
  assign wr_fmt  = reg_we_i && (reg_addr_i == ADDR_W'(A_FMT));
  assign wr_divl = reg_we_i && (reg_addr_i == ADDR_W'(A_DIVL));
  assign wr_divh = reg_we_i && (reg_addr_i == ADDR_W'(A_DIVH));
  assign wr_mask = reg_we_i && (reg_addr_i == ADDR_W'(A_MASK));
  assign rd_data = reg_re_i && (reg_addr_i == ADDR_W'(A_DATA));
  assign div_wr  = wr_divl || wr_divh;
  assign fmt     = fmt_t'(fmt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= 5'b00011;
      div_q  <= DIV_W'(1);
      mask_q <= '0;
    end else begin
      if (wr_fmt)  fmt_q        <= reg_wdata_i[4:0];
      if (wr_divl) div_q[7:0]   <= reg_wdata_i;
      if (wr_divh) div_q[15:8]  <= reg_wdata_i;
      if (wr_mask) mask_q       <= reg_wdata_i[1:0];
    end
  end

  // transmit holding register; a write in the take cycle queues the new word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
    end else if (wr_data) begin
      hold_valid_q <= 1'b1;
      hold_data_q  <= reg_wdata_i;
    end else if (tx_take) begin
      hold_valid_q <= 1'b0;
    end
  end

  // receive holding register; a completing character wins over a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= '0;
      rx_ready_q <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
    end else if (rx_done) begin
      rx_data_q  <= rx_byte;
      rx_ready_q <= 1'b1;
      perr_q     <= rx_perr;
      ferr_q     <= rx_ferr;
    end else if (rd_data) begin
      rx_ready_q <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
    end
  end

  uart_fmt_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_q),
    .restart_i(div_wr),
    .tick_o   (tick)
  );

  uart_fmt_tx #(.OVS(OVS)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .fmt_i       (fmt),
    .hold_valid_i(hold_valid_q),
    .hold_data_i (hold_data_q),
    .take_o      (tx_take),
    .busy_o      (tx_busy),
    .bits_left_o (tx_left),
    .tx_o        (tx_o)
  );

  uart_fmt_rx #(.OVS(OVS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .len_code_i(fmt.len_code),
    .par_i     (fmt.par),
    .rxd_i     (rxd_i),
    .done_o    (rx_done),
    .data_o    (rx_byte),
    .perr_o    (rx_perr),
    .ferr_o    (rx_ferr)
  );

  assign status = {3'b000, !tx_busy && !hold_valid_q, ferr_q, perr_q, !hold_valid_q, rx_ready_q};

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(A_DATA): reg_rdata_o = rx_data_q;
      ADDR_W'(A_FMT):  reg_rdata_o = {3'b000, fmt_q};
      ADDR_W'(A_DIVL): reg_rdata_o = div_q[7:0];
      ADDR_W'(A_DIVH): reg_rdata_o = div_q[15:8];
      ADDR_W'(A_MASK): reg_rdata_o = {6'b0, mask_q};
      ADDR_W'(A_STAT): reg_rdata_o = status;
      default:         reg_rdata_o = '0;
    endcase
  end

  assign irq_rx_o = mask_q[0] && rx_ready_q;
  assign irq_tx_o = mask_q[1] && !hold_valid_q;
endmodule

// File: rtl/uart_fmt_chk.sv
module uart_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        div_wr_i,
  input logic [15:0] div_i,
  input logic        rd_data_i,
  input logic        rx_done_i,
  input logic        rx_ready_i,
  input logic        perr_i,
  input logic        ferr_i,
  input logic        irq_rx_i,
  input logic        irq_tx_i,
  input logic        hold_valid_i,
  input logic        take_i,
  input logic        tx_busy_i,
  input logic [3:0]  left_i,
  input logic        tx_i
);
  p_tick_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != 16'd1 && !div_wr_i) |=> !tick_i);

  p_ready_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !rx_done_i) |=> !rx_ready_i);

  p_ready_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready_i) |-> $past(rx_done_i));

  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !rx_done_i) |=> (!perr_i && !ferr_i));

  p_irq_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_i |-> rx_ready_i);

  p_irq_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_i |-> !hold_valid_i);

  p_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> tx_busy_i);

  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i && left_i == 4'd1) |-> tx_i);

  p_frame_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (left_i >= 4'd7 && left_i <= 4'd12));
endmodule

bind uart_fmt_top uart_fmt_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .div_wr_i    (div_wr),
  .div_i       (div_q),
  .rd_data_i   (rd_data),
  .rx_done_i   (rx_done),
  .rx_ready_i  (rx_ready_q),
  .perr_i      (perr_q),
  .ferr_i      (ferr_q),
  .irq_rx_i    (irq_rx_o),
  .irq_tx_i    (irq_tx_o),
  .hold_valid_i(hold_valid_q),
  .take_i      (tx_take),
  .tx_busy_i   (tx_busy),
  .left_i      (tx_left),
  .tx_i        (tx_o)
);

// File: tb/uart_fmt_top_tb.sv
module uart_fmt_top_tb;
  logic       clk = 1'b0, rst_ni = 1'b0, we = 1'b0, re = 1'b0, rxd = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx, irq_rx, irq_tx;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uart_fmt_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rxd_i(rxd), .tx_o(tx),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  // Behavioural character image, first bit on the line at index 0.
  task automatic mk(input logic [7:0] d, input int len, input int pm, input bit two,
                    output logic [11:0] v, output int n);
    int ones = 0;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < len; i++) begin
      v[1+i] = d[i];
      ones += int'(d[i]);
    end
    n = 1 + len;
    if (pm == 1 || pm == 2) begin
      v[n] = (pm == 1) ? ((ones % 2) == 1) : ((ones % 2) == 0);
      n++;
    end
    n += two ? 2 : 1;
  endtask

  // Wait for the start edge on tx, then sample n bits at mid-bit.
  task automatic grab(input int div, input int n, output logic [23:0] bits);
    int t = 0;
    bits = '1;
    while (tx !== 1'b0) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int target = 16 * div * k + 8 * div;
      repeat (target - t) @(negedge clk);
      t = target;
      bits[k] = tx;
    end
  endtask

  task automatic send(input int div, input logic [7:0] d, input int len, input int pm,
                      input bit two, input bit bad_par, input bit bad_stop);
    logic [11:0] v;
    int n;
    mk(d, len, pm, two, v, n);
    if (bad_par) v[1+len] = ~v[1+len];
    if (bad_stop) v[1+len+((pm == 1 || pm == 2) ? 1 : 0)] = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rxd = v[k];
      repeat (16 * div - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0]  s;
    logic [23:0] b;
    logic [11:0] e1, e2;
    int n1, n2;

    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10", "tx idle", int'(tx), 1);
    chk("R10", "irqs", int'({irq_rx, irq_tx}), 0);
    rd(3'd5, s); chk("R10", "status", int'(s), 8'h12);
    rd(3'd1, s); chk("R10", "format", int'(s), 8'h03);
    rd(3'd2, s); chk("R10", "divisor low", int'(s), 8'h01);

    wr(3'd2, 8'd2);
    wr(3'd4, 8'h02);
    chk("R7", "irq_tx when holding empty", int'(irq_tx), 1);

    // R1 R5: 8N1 back-to-back through the holding register
    fork
      grab(2, 20, b);
      begin
        wr(3'd0, 8'hA5);
        wr(3'd0, 8'h3C);
        rd(3'd5, s);
        chk("R5", "holding full while shifting", int'(s[1]), 0);
        chk("R7", "irq_tx low while holding full", int'(irq_tx), 0);
      end
    join
    mk(8'hA5, 8, 0, 1'b0, e1, n1);
    mk(8'h3C, 8, 0, 1'b0, e2, n2);
    chk("R5", "8N1 two characters", int'(b[19:0]), int'({e2[9:0], e1[9:0]}));
    repeat (64) @(negedge clk);
    chk("R7", "irq_tx after drain", int'(irq_tx), 1);
    rd(3'd5, s); chk("R5", "status idle", int'(s), 8'h12);

    // R1 R2 R3: 5 bits, odd parity, two stops, upper bits of byte ignored
    wr(3'd1, 8'h14);
    fork
      grab(2, 18, b);
      begin wr(3'd0, 8'hF3); wr(3'd0, 8'h0C); end
    join
    mk(8'hF3, 5, 2, 1'b1, e1, n1);
    mk(8'h0C, 5, 2, 1'b1, e2, n2);
    chk("R2", "5O2 two characters", int'(b[17:0]), int'({e2[8:0], e1[8:0]}));
    repeat (64) @(negedge clk);

    // R3: 7 bits even parity, one stop, then idle
    wr(3'd1, 8'h0A);
    fork
      grab(2, 11, b);
      wr(3'd0, 8'h41);
    join
    mk(8'h41, 7, 1, 1'b0, e1, n1);
    chk("R3", "7E1 character then idle", int'(b[10:0]), int'({1'b1, e1[9:0]}));
    repeat (64) @(negedge clk);

    // R2: 6N1 back-to-back, next start follows the single stop
    wr(3'd1, 8'h01);
    fork
      grab(2, 16, b);
      begin wr(3'd0, 8'h2A); wr(3'd0, 8'h15); end
    join
    mk(8'h2A, 6, 0, 1'b0, e1, n1);
    mk(8'h15, 6, 0, 1'b0, e2, n2);
    chk("R2", "6N1 two characters", int'(b[15:0]), int'({e2[7:0], e1[7:0]}));
    repeat (64) @(negedge clk);

    // R6 R7 R1: receive 8N1 with interrupt masked, then enabled
    wr(3'd1, 8'h03);
    wr(3'd4, 8'h00);
    send(2, 8'h5A, 8, 0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rd(3'd5, s); chk("R6", "rx ready", int'(s[0]), 1);
    chk("R7", "irq_rx masked", int'(irq_rx), 0);
    wr(3'd4, 8'h01);
    chk("R7", "irq_rx enabled", int'(irq_rx), 1);
    rd(3'd0, s); chk("R1", "rx data 8 bits", int'(s), 8'h5A);
    rd(3'd5, s); chk("R6", "ready cleared by read", int'(s[0]), 0);
    chk("R7", "irq_rx after read", int'(irq_rx), 0);

    // R1 R3: receive 5 bits odd parity, read back zero-extended
    wr(3'd1, 8'h10);
    send(2, 8'hF5, 5, 2, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rd(3'd5, s); chk("R3", "5O1 no errors", int'(s[3:2]), 0);
    rd(3'd0, s); chk("R1", "rx data 5 bits", int'(s), 8'h15);

    // R9 R3: parity error on even parity
    wr(3'd1, 8'h0B);
    send(2, 8'h33, 8, 1, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    rd(3'd5, s); chk("R9", "parity error flags", int'(s[3:2]), 2'b01);
    rd(3'd0, s); chk("R9", "data with parity error", int'(s), 8'h33);
    rd(3'd5, s); chk("R9", "flags cleared", int'(s[3:0]), 4'b0010);

    // R9: framing error
    wr(3'd1, 8'h03);
    send(2, 8'h81, 8, 0, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    rd(3'd5, s); chk("R9", "framing error flags", int'(s[3:2]), 2'b10);
    rd(3'd0, s);
    rd(3'd5, s); chk("R9", "framing cleared", int'(s[3:0]), 4'b0010);

    // R6: first word readable while the second shifts in
    send(2, 8'h11, 8, 0, 1'b0, 1'b0, 1'b0);
    fork
      send(2, 8'h22, 8, 0, 1'b0, 1'b0, 1'b0);
      begin
        repeat (10) @(negedge clk);
        rd(3'd0, s); chk("R6", "first word during second", int'(s), 8'h11);
        rd(3'd5, s); chk("R6", "ready clear mid character", int'(s[0]), 0);
      end
    join
    repeat (4) @(negedge clk);
    rd(3'd0, s); chk("R6", "second word", int'(s), 8'h22);

    // R8: short low pulse rejected, then a real character received
    @(negedge clk); rxd = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
    rd(3'd5, s); chk("R8", "glitch gives no character", int'(s[0]), 0);
    send(2, 8'h96, 8, 0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rd(3'd0, s); chk("R8", "character after glitch", int'(s), 8'h96);

    // R4: divisor with high byte set (257)
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, s); chk("R4", "divisor high readback", int'(s), 8'h01);
    fork
      grab(257, 7, b);
      wr(3'd0, 8'h0B);
    join
    mk(8'h0B, 5, 0, 1'b0, e1, n1);
    chk("R4", "5N1 at divisor 257", int'(b[6:0]), int'(e1[6:0]));
    repeat (16 * 257) @(negedge clk);

    // R4: divisor 0 means 65536, start bit still low far beyond short divisors
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h00);
    while (tx !== 1'b0) @(negedge clk);
    repeat (100000) @(negedge clk);
    chk("R4", "start bit at divisor 0", int'(tx), 0);

    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "tx after reset", int'(tx), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    report();
  end
endmodule